// File: doc/BRIEF.md
# Two-Level Aperture Address Translator

This block maps bus addresses that fall inside a graphics aperture onto physical addresses. It walks a two-level table. The first level is a directory of 64 slots held in on-chip registers. Each present slot names the 4 KB page that holds 1024 second-level entries, so one slot covers 4 MB of aperture. Software fills a slot with one packed 32-bit write to a configuration register. For each request the block reads the second-level entry through a simple read request and response port. A small fully associative cache keeps recent page translations, which saves the memory read.

The block serves one request at a time. A response is a one-cycle pulse that carries either the translated address or a fault. The aperture starts at the base set by the `APER_BASE` parameter. Its size is one of four values, selected by a size register, and the number of directory slots in use scales with that size. Software flushes the cache by clearing a control bit and then setting it again. Any write to the directory register also flushes the cache.

Top module: `aperture_xlate`

## Requirements
- R1: A write to config offset 0xB8 loads one directory slot. The slot number is in bits 5:0, the present flag is in bit 8, and the second-level table page frame is in bits 31:12. Bits 11:9 (attribute index) and bits 7:6 do not change translation.
- R2: A write to offset 0xB8 with bit 8 clear empties the named slot. A later request that maps to that slot faults and makes no memory read.
- R3: The size register sits at offset 0xB4, and bits 1:0 select the aperture size: 0 is 32 MB, 1 is 64 MB, 2 is 128 MB and 3 is 256 MB. The reset value is 0. An address below the base, or at or above base plus size, faults and makes no memory read.
- R4: The slot index is bits 27:22 of (address minus base). The second-level entry is read from {slot frame, address bits 21:12, 2'b00}.
- R5: A second-level entry with bit 0 set gives the response address {entry bits 31:12, request address bits 11:0}, with no fault.
- R6: A second-level entry with bit 0 clear gives a fault response, and the response address is zero.
- R7: A second request to a page that is already cached completes with no memory read.
- R8: The cache holds 4 entries and replaces them round-robin. After five distinct pages are filled, the first page misses again while the third page still hits.
- R9: A write to offset 0xB0 whose bit 7 goes from 0 to 1 empties the cache. A write with bit 7 set while bit 7 is already set does not empty it.
- R10: Any write to offset 0xB8 empties the cache.
- R11: `req_ready` goes low from the cycle after a request is accepted until the response is delivered. `rsp_valid` is high for one cycle only. Each cache miss makes exactly one memory read.
- R12: After reset, `req_ready` is 1, and both `rsp_valid` and `mem_rd_valid` are 0. Every directory slot is empty, so any request faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | 8 | Config register offset |
| cfg_wdata | input | 32 | Config write data |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Bus address to translate |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_fault | output | 1 | Translation failed |
| rsp_addr | output | 32 | Translated physical address (zero on fault) |
| mem_rd_valid | output | 1 | Second-level entry read request |
| mem_rd_addr | output | 32 | Address of the second-level entry |
| mem_rd_data_valid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Second-level entry |

## Verification
A stale or missing cache entry shows up in the next translation of that page. Either a memory read appears where none was due, or a translated address differs from the one the walk would give. Both show in the response two or three cycles after the request. A wrong directory slot, or a wrong range decision, shows in the address of the memory read or in an unexpected fault. This happens in the cycle right after the request is accepted. Handshake faults show as `req_ready` rising too early, or as a response pulse longer than one cycle.

// File: rtl/apx_pkg.sv
package apx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CHECK = 2'd1,
      ST_WAIT  = 2'd2,
      ST_RSP   = 2'd3
   } walk_state_t;

   localparam int PAGE_SHIFT = 12;
   localparam int SLOT_SHIFT = 22;
   localparam int L2_IDX_W   = SLOT_SHIFT - PAGE_SHIFT;
   localparam int FRAME_W    = 32 - PAGE_SHIFT;
   localparam int SLOT_FIELD_W = 6;
endpackage

// File: rtl/apx_dir.sv
module apx_dir #(
   parameter int SLOTS   = 64,
   parameter int IDX_W   = 6,
   parameter int FRAME_W = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic               wr_present,
   input  logic [FRAME_W-1:0] wr_frame,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic               rd_present,
   output logic [FRAME_W-1:0] rd_frame
);
   logic [SLOTS-1:0]   present_q;
   logic [FRAME_W-1:0] frame_q [SLOTS];
   logic               wr_hit;

   assign wr_hit = wr_en && (32'(wr_idx) < SLOTS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         present_q <= '0;
      end else if (wr_hit) begin
         present_q[wr_idx] <= wr_present;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_hit) frame_q[wr_idx] <= wr_frame;
   end

   always_comb begin
      rd_present = 1'b0;
      rd_frame   = '0;
      if (32'(rd_idx) < SLOTS) begin
         rd_present = present_q[rd_idx];
         rd_frame   = frame_q[rd_idx];
      end
   end

   // R1/R2: a slot write is visible at the read side on the next cycle
   assert_slot_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && rd_idx == wr_idx) |=> (rd_idx != $past(wr_idx)) || (rd_present == $past(wr_present)));
endmodule

// File: rtl/apx_tcache.sv
module apx_tcache #(
   parameter int ENTRIES = 4,
   parameter int TAG_W   = 16,
   parameter int DATA_W  = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [TAG_W-1:0]  look_tag,
   output logic              hit,
   output logic [DATA_W-1:0] hit_data,
   input  logic              fill_en,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic [DATA_W-1:0] fill_data
);
   localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   logic [ENTRIES-1:0] valid_q;
   logic [ENTRIES-1:0] match;
   logic [TAG_W-1:0]   tag_q  [ENTRIES];
   logic [DATA_W-1:0]  data_q [ENTRIES];
   logic [PTR_W-1:0]   ptr_q;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_way
      assign match[e] = valid_q[e] && (tag_q[e] == look_tag);
      always_ff @(posedge clk) begin
         if (fill_en && 32'(ptr_q) == e) begin
            tag_q[e]  <= fill_tag;
            data_q[e] <= fill_data;
         end
      end
   end

   always_comb begin
      hit_data = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (match[e]) hit_data = hit_data | data_q[e];
      end
   end
   assign hit = |match;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         ptr_q   <= '0;
      end else if (flush) begin
         valid_q <= '0;
      end else if (fill_en) begin
         valid_q[ptr_q] <= 1'b1;
         ptr_q <= (32'(ptr_q) == ENTRIES - 1) ? '0 : ptr_q + 1'b1;
      end
   end

   // R8: a page is never held twice
   assert_unique_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));
   // R9/R10: a flush empties every entry in the next cycle
   assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid_q == '0));
   // R7: a filled page hits on the following cycle unless flushed
   assert_fill_hits_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && !flush && look_tag == fill_tag) |=> (look_tag != $past(fill_tag)) || hit);
endmodule

// File: rtl/aperture_xlate.sv
module aperture_xlate #(
   parameter logic [31:0] APER_BASE     = 32'h8000_0000,
   parameter int          DIR_SLOTS     = 64,
   parameter int          CACHE_ENTRIES = 4,
   parameter logic [7:0]  DIR_REG_OFS   = 8'hB8,
   parameter logic [7:0]  CTRL_REG_OFS  = 8'hB0,
   parameter logic [7:0]  SIZE_REG_OFS  = 8'hB4,
   parameter int          FLUSH_BIT     = 7
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic [7:0]  cfg_addr,
   input  logic [31:0] cfg_wdata,
   input  logic        req_valid,
   output logic        req_ready,
   input  logic [31:0] req_addr,
   output logic        rsp_valid,
   output logic        rsp_fault,
   output logic [31:0] rsp_addr,
   output logic        mem_rd_valid,
   output logic [31:0] mem_rd_addr,
   input  logic        mem_rd_data_valid,
   input  logic [31:0] mem_rd_data
);
   import apx_pkg::*;

   localparam int IDX_W  = SLOT_FIELD_W;
   localparam int TAG_W  = IDX_W + L2_IDX_W;
   localparam int SPAN_W = 32 - SLOT_SHIFT;

   if (DIR_SLOTS < 8 || DIR_SLOTS > 64 || (DIR_SLOTS & (DIR_SLOTS - 1)) != 0) begin : g_bad_slots
      $error("DIR_SLOTS must be a power of two from 8 to 64");
   end
   if (APER_BASE[SLOT_SHIFT-1:0] != '0) begin : g_bad_base
      $error("APER_BASE must be aligned to a directory span");
   end
   if (FLUSH_BIT < 0 || FLUSH_BIT > 31) begin : g_bad_bit
      $error("FLUSH_BIT out of range");
   end

   walk_state_t        state_q;
   logic [31:0]        addr_q;
   logic               flush_bit_q;
   logic [1:0]         size_sel_q;
   logic               rsp_fault_q;
   logic [31:0]        rsp_addr_q;

   logic               dir_we, ctrl_we, size_we, cache_flush;
   logic [31:0]        offset;
   logic [IDX_W:0]     slots_used;
   logic               in_range;
   logic [IDX_W-1:0]   slot_idx;
   logic               slot_present;
   logic [FRAME_W-1:0] slot_frame;
   logic               c_hit, c_fill;
   logic [FRAME_W-1:0] c_data;

   assign dir_we  = cfg_we && (cfg_addr == DIR_REG_OFS);
   assign ctrl_we = cfg_we && (cfg_addr == CTRL_REG_OFS);
   assign size_we = cfg_we && (cfg_addr == SIZE_REG_OFS);
   assign cache_flush = dir_we || (ctrl_we && cfg_wdata[FLUSH_BIT] && !flush_bit_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flush_bit_q <= 1'b0;
         size_sel_q  <= 2'd0;
      end else begin
         if (ctrl_we) flush_bit_q <= cfg_wdata[FLUSH_BIT];
         if (size_we) size_sel_q  <= cfg_wdata[1:0];
      end
   end

   assign offset     = addr_q - APER_BASE;
   assign slots_used = (IDX_W+1)'(DIR_SLOTS >> (2'd3 - size_sel_q));
   assign in_range   = (addr_q >= APER_BASE) &&
                       (offset[31:SLOT_SHIFT] < SPAN_W'(slots_used));
   assign slot_idx   = offset[SLOT_SHIFT+IDX_W-1:SLOT_SHIFT];

   apx_dir #(.SLOTS(DIR_SLOTS), .IDX_W(IDX_W), .FRAME_W(FRAME_W)) u_dir (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (dir_we),
      .wr_idx     (cfg_wdata[IDX_W-1:0]),
      .wr_present (cfg_wdata[8]),
      .wr_frame   (cfg_wdata[31:PAGE_SHIFT]),
      .rd_idx     (slot_idx),
      .rd_present (slot_present),
      .rd_frame   (slot_frame)
   );

   assign c_fill = (state_q == ST_WAIT) && mem_rd_data_valid && mem_rd_data[0];

   if (CACHE_ENTRIES > 0) begin : g_cache
      apx_tcache #(.ENTRIES(CACHE_ENTRIES), .TAG_W(TAG_W), .DATA_W(FRAME_W)) u_cache (
         .clk       (clk),
         .rst_n     (rst_n),
         .flush     (cache_flush),
         .look_tag  (offset[SLOT_SHIFT+IDX_W-1:PAGE_SHIFT]),
         .hit       (c_hit),
         .hit_data  (c_data),
         .fill_en   (c_fill),
         .fill_tag  (offset[SLOT_SHIFT+IDX_W-1:PAGE_SHIFT]),
         .fill_data (mem_rd_data[31:PAGE_SHIFT])
      );
   end else begin : g_nocache
      assign c_hit  = 1'b0;
      assign c_data = '0;
   end

   assign mem_rd_valid = (state_q == ST_CHECK) && in_range && slot_present && !c_hit;
   assign mem_rd_addr  = {slot_frame, addr_q[SLOT_SHIFT-1:PAGE_SHIFT], 2'b00};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         addr_q      <= '0;
         rsp_fault_q <= 1'b0;
         rsp_addr_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (req_valid) begin
               addr_q  <= req_addr;
               state_q <= ST_CHECK;
            end
            ST_CHECK: begin
               if (!in_range || !slot_present) begin
                  rsp_fault_q <= 1'b1;
                  rsp_addr_q  <= '0;
                  state_q     <= ST_RSP;
               end else if (c_hit) begin
                  rsp_fault_q <= 1'b0;
                  rsp_addr_q  <= {c_data, addr_q[PAGE_SHIFT-1:0]};
                  state_q     <= ST_RSP;
               end else begin
                  state_q <= ST_WAIT;
               end
            end
            ST_WAIT: if (mem_rd_data_valid) begin
               rsp_fault_q <= !mem_rd_data[0];
               rsp_addr_q  <= mem_rd_data[0] ?
                              {mem_rd_data[31:PAGE_SHIFT], addr_q[PAGE_SHIFT-1:0]} : '0;
               state_q     <= ST_RSP;
            end
            ST_RSP: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign rsp_valid = (state_q == ST_RSP);
   assign rsp_fault = rsp_fault_q;
   assign rsp_addr  = rsp_addr_q;

   assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   assert_rsp_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   assert_rsp_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);
   assert_read_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |-> !req_ready);
   assert_fault_zero_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_addr == 32'd0));
endmodule

// File: tb/aperture_xlate_tb.sv
module aperture_xlate_tb;
   localparam logic [31:0] BASE = 32'h8000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic        rsp_valid, rsp_fault;
   logic [31:0] rsp_addr;
   logic        mem_rd_valid;
   logic [31:0] mem_rd_addr;
   logic        mem_rd_data_valid = 1'b0;
   logic [31:0] mem_rd_data = '0;

   int errors = 0;
   int checks = 0;
   int reads  = 0;
   logic [31:0] last_ma = '0;
   logic        pend = 1'b0;
   logic [31:0] pend_ma = '0;

   logic        sh_present [64];
   logic [19:0] sh_frame   [64];
   int          sh_slots = 8;

   always #5 clk = ~clk;

   aperture_xlate u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_addr(rsp_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
      .mem_rd_data_valid(mem_rd_data_valid), .mem_rd_data(mem_rd_data)
   );

   function automatic logic [31:0] pte_of(input logic [31:0] ma);
      logic [19:0] fr;
      fr = ma[31:12] ^ {10'd0, ma[11:2]};
      return {fr, 11'd0, (ma[11:2] != 10'h3FF)};
   endfunction

   // memory model: answers one cycle after it sees a read
   always @(negedge clk) begin
      mem_rd_data_valid <= 1'b0;
      if (pend) begin
         mem_rd_data_valid <= 1'b1;
         mem_rd_data <= pte_of(pend_ma);
         pend <= 1'b0;
      end
      if (mem_rd_valid) begin
         pend <= 1'b1;
         pend_ma <= mem_rd_addr;
         last_ma <= mem_rd_addr;
         reads <= reads + 1;
      end
   end

   task automatic check(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", msg, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (a == 8'hB8 && (d[8] == 1'b1 || d[8] == 1'b0)) begin
         sh_present[d[5:0]] = d[8];
         sh_frame[d[5:0]]   = d[31:12];
      end
      if (a == 8'hB4) sh_slots = 8 << d[1:0];
   endtask

   // model of the expected translation
   task automatic model(input logic [31:0] a, output logic f, output logic [31:0] o,
                        output logic [31:0] ma, output logic walk);
      logic [31:0] off;
      logic [31:0] p;
      off = a - BASE;
      f = 1'b1; o = '0; ma = '0; walk = 1'b0;
      if (a >= BASE && int'(off[31:22]) < sh_slots && sh_present[off[27:22]]) begin
         walk = 1'b1;
         ma = {sh_frame[off[27:22]], a[21:12], 2'b00};
         p = pte_of(ma);
         if (p[0]) begin
            f = 1'b0;
            o = {p[31:12], a[11:0]};
         end
      end
   endtask

   task automatic xlate(input logic [31:0] a, output logic f, output logic [31:0] o, output int nrd);
      int r0;
      bit got;
      bit busy_ok;
      r0 = reads;
      got = 0; busy_ok = 1;
      f = 1'b0; o = '0;
      @(negedge clk);
      req_valid = 1'b1; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      for (int c = 0; c < 40 && !got; c++) begin
         if (rsp_valid) begin
            got = 1; f = rsp_fault; o = rsp_addr;
            if (req_ready) busy_ok = 0;
         end else begin
            if (req_ready) busy_ok = 0;
            @(negedge clk);
         end
      end
      @(negedge clk);
      check(got && busy_ok && !rsp_valid && req_ready, "R11 handshake", {31'd0, rsp_valid}, 32'd0);
      nrd = reads - r0;
   endtask

   typedef struct packed {
      logic [31:0] a;
      logic        f;
      logic        miss;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{32'h8000_1234, 1'b0, 1'b1},  // R4/R5 fresh walk
      '{32'h8000_1FFC, 1'b0, 1'b0},  // R7 same page hits
      '{32'h8040_2008, 1'b0, 1'b1},  // R1 slot written with attribute/reserved bits
      '{32'h803F_F010, 1'b1, 1'b1},  // R6 entry bit 0 clear
      '{32'h8080_0000, 1'b1, 1'b0},  // R2 empty slot
      '{32'h7FFF_F000, 1'b1, 1'b0},  // R3 below base
      '{32'h8200_0000, 1'b1, 1'b0},  // R3 past 32 MB
      '{32'h8000_1000, 1'b0, 1'b0}   // R7 hit again
   };

   logic        fo, fe, walk;
   logic [31:0] oo, oe, mae;
   int          nrd;

   initial begin
      #2_000_000;
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) begin
         sh_present[i] = 1'b0; sh_frame[i] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      check(req_ready === 1'b1, "R12 req_ready after reset", {31'd0, req_ready}, 32'd1);
      check(rsp_valid === 1'b0 && mem_rd_valid === 1'b0, "R12 outputs idle",
            {30'd0, rsp_valid, mem_rd_valid}, 32'd0);
      xlate(32'h8000_0000, fo, oo, nrd);
      check(fo === 1'b1 && nrd == 0, "R12 empty directory faults", {31'd0, fo}, 32'd1);

      cfg_write(8'hB8, {20'h12345, 3'b000, 1'b1, 2'b00, 6'd0});
      cfg_write(8'hB8, {20'h00ABC, 3'b111, 1'b1, 2'b11, 6'd1});

      foreach (VECS[i]) begin
         xlate(VECS[i].a, fo, oo, nrd);
         model(VECS[i].a, fe, oe, mae, walk);
         check(fo === VECS[i].f && fe === VECS[i].f, $sformatf("R5/R6 fault vec %0d", i),
               {31'd0, fo}, {31'd0, VECS[i].f});
         check(oo === oe, $sformatf("R5 address vec %0d", i), oo, oe);
         check(nrd == int'(VECS[i].miss), $sformatf("R7/R11 reads vec %0d", i), nrd, {31'd0, VECS[i].miss});
         if (VECS[i].miss)
            check(last_ma === mae, $sformatf("R4 entry address vec %0d", i), last_ma, mae);
      end

      // R3 larger aperture opens slot 8
      cfg_write(8'hB4, 32'd1);
      cfg_write(8'hB8, {20'h0F00F, 3'b000, 1'b1, 2'b00, 6'd8});
      xlate(32'h8200_3004, fo, oo, nrd);
      model(32'h8200_3004, fe, oe, mae, walk);
      check(fo === 1'b0 && oo === oe && nrd == 1, "R3 64MB size reaches slot 8", oo, oe);
      xlate(32'h8400_0000, fo, oo, nrd);
      check(fo === 1'b1 && nrd == 0, "R3 past 64MB faults", {31'd0, fo}, 32'd1);

      // R2 clearing a slot
      cfg_write(8'hB8, {20'h0F00F, 3'b000, 1'b0, 2'b00, 6'd8});
      xlate(32'h8200_3004, fo, oo, nrd);
      check(fo === 1'b1 && nrd == 0, "R2 cleared slot faults", {31'd0, fo}, 32'd1);

      // R9 flush by clear then set
      xlate(32'h8000_1000, fo, oo, nrd);              // fill after R10 flush
      xlate(32'h8000_1000, fo, oo, nrd);
      check(nrd == 0, "R7 cached page", nrd, 0);
      cfg_write(8'hB0, 32'h0000_2200);
      cfg_write(8'hB0, 32'h0000_2280);
      xlate(32'h8000_1000, fo, oo, nrd);
      check(nrd == 1, "R9 rising bit 7 flushes", nrd, 1);
      cfg_write(8'hB0, 32'h0000_2280);
      xlate(32'h8000_1000, fo, oo, nrd);
      check(nrd == 0, "R9 bit 7 held high does not flush", nrd, 0);

      // R10 directory write flushes
      cfg_write(8'hB8, {20'h00ABC, 3'b000, 1'b1, 2'b00, 6'd1});
      xlate(32'h8000_1000, fo, oo, nrd);
      check(nrd == 1, "R10 directory write flushes", nrd, 1);

      // R8 round-robin replacement
      cfg_write(8'hB0, 32'h0000_2200);
      cfg_write(8'hB0, 32'h0000_2280);
      for (int k = 0; k < 5; k++) xlate(BASE + 32'(k) * 32'h1000, fo, oo, nrd);
      xlate(BASE, fo, oo, nrd);
      check(nrd == 1, "R8 oldest page evicted", nrd, 1);
      xlate(BASE + 32'h2000, fo, oo, nrd);
      check(nrd == 0, "R8 third page still held", nrd, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule